// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Sequencer

This block sits between an on-chip request/acknowledge bus and one external asynchronous static RAM of 131,072 bytes. A requester presents an address, a direction and (for writes) a byte; the controller turns that into a timed sequence of three active-low strobes (chip select, write strobe, output enable), a 17-bit address and an 8-bit data bus. The data bus is split into a separate output, input and driver-enable so that the pad ring can build the tri-state buffer.

Each access is a sequence of phases held by one down-counter. Every phase length comes from a nanosecond limit, converted at elaboration into whole clock cycles: round up, with at least one cycle. Two parameters choose the write style. With the default style, the write strobe shapes the write while output enable stays high, which allows the short pulse. A second style keeps output enable low throughout the write, which needs the long pulse. A third style lowers the write strobe first and lets chip select shape the pulse. In every style, the controller turns its drivers on only after the memory's outputs have had the turnaround time to float. It holds write data for the hold time after the pulse ends. It returns the memory to standby (chip select high) whenever no access is under way.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, mem_ce_n_o, mem_we_n_o and mem_oe_n_o are 1, mem_dq_oe_o is 0 and ack_o is 0. The memory is in standby in the cycle ack_o is high and in the cycle after it.
- R2: A read holds mem_ce_n_o=0, mem_we_n_o=1 and mem_oe_n_o=0 with the address stable and the data drivers off.
- R3: Read data sampled from mem_dq_i in the last read cycle appears on rdata_o in the same cycle that ack_o rises. ack_o rises RD_CYC clock edges after the edge that accepts the read.
- R4: The write pulse (mem_ce_n_o and mem_we_n_o both 0) lasts at least WP_CYC cycles. WP_CYC is derived from the short pulse limit when output enable is held high during writes, and from the long limit when output enable is held low (OE_LOW_WR=1).
- R5: mem_dq_oe_o is never 1 while the read strobe combination is active or in the cycle after it. Before it rises, the memory outputs have floated for TURN_CYC cycles: output enable is high, or the write strobe is low in the low-output-enable style.
- R6: The drivers stay on, with unchanged address and data, for at least DH_CYC cycles after the write pulse ends. They are released only after a cycle with no write pulse.
- R7: With CE_CTRL_WR=1 the write strobe is already low in the cycle before chip select falls for a write, and it is still low in the cycle where chip select rises again.
- R8: ack_o is high for exactly one cycle per access. A request is accepted only while the controller is idle and ack_o is low. A write is acknowledged TURN_CYC+WP_CYC+DH_CYC edges after the accepting edge.
- R9: Every phase length is max(1, ceil(limit_ps / CLK_PS)) cycles, so a read strobe lasts exactly RD_CYC cycles.
- R10: With OE_LOW_WR=1, mem_oe_n_o is 0 in every write-pulse cycle. In the other styles it is 1 in every write-pulse cycle.
- R11: All 17 address bits reach the memory unchanged, so a byte written at any address, including 0 and 0x1FFFF, reads back from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled when idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write byte |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last byte read |
| mem_addr_o | output | ADDR_W | Memory address lines |
| mem_dq_o | output | DATA_W | Data to the memory |
| mem_dq_i | input | DATA_W | Data from the memory |
| mem_dq_oe_o | output | 1 | Enable of the data drivers |
| mem_ce_n_o | output | 1 | Chip select, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |

## Verification
Three instances run the same request stream: the default style, the chip-select-shaped style, and the low-output-enable style with a longer pulse limit. Each drives its own memory model. The corner cases are back-to-back read-after-write and write-after-read at one address, and the address extremes. A design that skipped the turnaround would be flagged by the model for driving the bus while the memory is still driving it. A design that dropped data before the pulse ended would store a wrong byte. A design that rounded a limit down would show a short pulse or a wrong acknowledge latency. A design that left chip select low between accesses would fail the standby check taken after every acknowledge.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_READ,
      PH_WSET,
      PH_WPULSE,
      PH_WHOLD
   } phase_e;

   // Limit in picoseconds to whole cycles, never less than one.
   function automatic int cyc_of(input int lim_ps, input int clk_ps);
      int c;
      c = (lim_ps + clk_ps - 1) / clk_ps;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
   import sram_seq_pkg::*;
#(
   parameter bit CE_CTRL = 1'b0,
   parameter bit OE_LOW  = 1'b0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e phase_d,
   output logic   ce_n,
   output logic   we_n,
   output logic   oe_n,
   output logic   drv
);

   // code = {ce_n, we_n, oe_n, drv}
   logic [3:0] code_d, code_q;

   generate
      if (CE_CTRL) begin : g_ce_shaped
         always_comb begin
            case (phase_d)
               PH_READ:   code_d = 4'b0100;
               PH_WSET:   code_d = 4'b1010;
               PH_WPULSE: code_d = 4'b0011;
               PH_WHOLD:  code_d = 4'b1011;
               default:   code_d = 4'b1110;
            endcase
         end
      end else if (OE_LOW) begin : g_oe_low
         always_comb begin
            case (phase_d)
               PH_READ:   code_d = 4'b0100;
               PH_WSET:   code_d = 4'b0000;
               PH_WPULSE: code_d = 4'b0001;
               PH_WHOLD:  code_d = 4'b0111;
               default:   code_d = 4'b1110;
            endcase
         end
      end else begin : g_we_shaped
         always_comb begin
            case (phase_d)
               PH_READ:   code_d = 4'b0100;
               PH_WSET:   code_d = 4'b0110;
               PH_WPULSE: code_d = 4'b0011;
               PH_WHOLD:  code_d = 4'b0111;
               default:   code_d = 4'b1110;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= 4'b1110;
      else        code_q <= code_d;
   end

   assign {ce_n, we_n, oe_n, drv} = code_q;

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W        = 17,
   parameter int DATA_W        = 8,
   parameter int CLK_PS        = 5000,
   parameter int T_RC_PS       = 10000,
   parameter int T_HZ_PS       = 5000,
   parameter int T_WP_SHORT_PS = 8000,
   parameter int T_WP_LONG_PS  = 10000,
   parameter int T_DS_PS       = 5000,
   parameter int T_DH_PS       = 0,
   parameter bit CE_CTRL_WR    = 1'b0,
   parameter bit OE_LOW_WR     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              req_we_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              ack_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_dq_o,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic              mem_dq_oe_o,
   output logic              mem_ce_n_o,
   output logic              mem_we_n_o,
   output logic              mem_oe_n_o
);

   localparam int RD_CYC   = cyc_of(T_RC_PS, CLK_PS);
   localparam int TURN_CYC = cyc_of(T_HZ_PS, CLK_PS);
   localparam int WP_CYC   = cyc_of(OE_LOW_WR ? T_WP_LONG_PS : T_WP_SHORT_PS, CLK_PS);
   localparam int DH_CYC   = cyc_of(T_DH_PS, CLK_PS);
   localparam int DS_CYC   = cyc_of(T_DS_PS, CLK_PS);
   localparam int MAX_CYC  = max2(max2(RD_CYC, TURN_CYC), max2(WP_CYC, DH_CYC));
   localparam int CNT_W    = $clog2(MAX_CYC + 1);

   generate
      if (CE_CTRL_WR && OE_LOW_WR) begin : g_bad_mode
         $error("chip-select-shaped writes need output enable held high");
      end
      if (WP_CYC < DS_CYC) begin : g_bad_setup
         $error("write pulse shorter than data setup");
      end
      if (ADDR_W < 1 || DATA_W < 1 || MAX_CYC > 250) begin : g_bad_size
         $error("unsupported width or phase length");
      end
   endgenerate

   phase_e            ph_q, ph_d;
   logic              ld, done, ack_q;
   logic [CNT_W-1:0]  ld_val;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;

   always_comb begin
      ph_d   = ph_q;
      ld     = 1'b0;
      ld_val = '0;
      case (ph_q)
         PH_IDLE: begin
            if (req_i && !ack_q) begin
               ld = 1'b1;
               if (req_we_i) begin
                  ph_d   = PH_WSET;
                  ld_val = CNT_W'(TURN_CYC - 1);
               end else begin
                  ph_d   = PH_READ;
                  ld_val = CNT_W'(RD_CYC - 1);
               end
            end
         end
         PH_READ:   if (done) ph_d = PH_IDLE;
         PH_WSET: begin
            if (done) begin
               ph_d   = PH_WPULSE;
               ld     = 1'b1;
               ld_val = CNT_W'(WP_CYC - 1);
            end
         end
         PH_WPULSE: begin
            if (done) begin
               ph_d   = PH_WHOLD;
               ld     = 1'b1;
               ld_val = CNT_W'(DH_CYC - 1);
            end
         end
         PH_WHOLD:  if (done) ph_d = PH_IDLE;
         default:   ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         ack_q   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         ph_q  <= ph_d;
         ack_q <= done && (ph_q == PH_READ || ph_q == PH_WHOLD);
         if (ph_q == PH_IDLE && ld) begin
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
         end
         if (ph_q == PH_READ && done) rdata_q <= mem_dq_i;
      end
   end

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .done     (done)
   );

   sram_strobe_gen #(.CE_CTRL(CE_CTRL_WR), .OE_LOW(OE_LOW_WR)) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_d (ph_d),
      .ce_n    (mem_ce_n_o),
      .we_n    (mem_we_n_o),
      .oe_n    (mem_oe_n_o),
      .drv     (mem_dq_oe_o)
   );

   assign ack_o      = ack_q;
   assign rdata_o    = rdata_q;
   assign mem_addr_o = addr_q;
   assign mem_dq_o   = wdata_q;

   // ---------------- checks on the memory-side waveform ----------------
   logic       wr_act, rd_act, wr_act_q, rd_act_q;
   logic [7:0] wr_len_q, rd_len_q;

   assign wr_act = !mem_ce_n_o && !mem_we_n_o;
   assign rd_act = !mem_ce_n_o &&  mem_we_n_o && !mem_oe_n_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_q <= 1'b0;
         rd_act_q <= 1'b0;
         wr_len_q <= '0;
         rd_len_q <= '0;
      end else begin
         wr_act_q <= wr_act;
         rd_act_q <= rd_act;
         wr_len_q <= wr_act ? ((wr_len_q == 8'hFF) ? wr_len_q : wr_len_q + 8'd1) : 8'd0;
         rd_len_q <= rd_act ? ((rd_len_q == 8'hFF) ? rd_len_q : rd_len_q + 8'd1) : 8'd0;
      end
   end

   a_r1_standby_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> mem_ce_n_o && !mem_dq_oe_o);
   a_r2_read_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && rd_act_q) |-> $stable(mem_addr_o));
   a_r4_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_act_q && !wr_act) |-> (wr_len_q >= 8'(WP_CYC)));
   a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe_o |-> !rd_act && !rd_act_q);
   a_r6_release_late: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_dq_oe_o) |-> !$past(wr_act));
   a_r6_drive_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o) && $stable(mem_addr_o));
   a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);
   a_r9_read_len: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act_q && !rd_act) |-> (rd_len_q == 8'(RD_CYC)));

   generate
      if (CE_CTRL_WR) begin : g_chk_ce
         a_r7_we_leads: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(mem_ce_n_o) && !mem_we_n_o) |-> !$past(mem_we_n_o));
         a_r7_we_trails: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(mem_ce_n_o) && $past(wr_act)) |-> !mem_we_n_o);
      end
      if (OE_LOW_WR) begin : g_chk_oel
         a_r10_oe_low_in_write: assert property (@(posedge clk) disable iff (!rst_n)
            wr_act |-> !mem_oe_n_o);
      end else begin : g_chk_oeh
         a_r10_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
            wr_act |-> mem_oe_n_o);
      end
   endgenerate

endmodule

// File: tb/async_ram_model.sv
module async_ram_model #(
   parameter int WP_MIN  = 2,
   parameter int RD_MIN  = 2,
   parameter bit OE_LOW  = 1'b0,
   parameter bit CE_MODE = 1'b0
) (
   input  logic        clk,
   input  logic [16:0] addr,
   input  logic [7:0]  dq_out,
   input  logic        dq_oe,
   input  logic        ce_n,
   input  logic        we_n,
   input  logic        oe_n,
   output logic [7:0]  dq_in,
   output int          checks,
   output int          fails
);

   logic [7:0]  mem [int];
   int          wr_len = 0, rd_len = 0;
   logic        was_wr = 1'b0, drove_q = 1'b0, we_low_q = 1'b0, oe_bad = 1'b0, lead_ok = 1'b1;
   logic [16:0] a_q = '0;
   logic [7:0]  d_q = '0;

   initial begin
      checks = 0;
      fails  = 0;
      dq_in  = 8'hEE;
   end

   always @(negedge clk) begin
      logic wr, rd;
      wr = !ce_n && !we_n;
      rd = !ce_n && we_n && !oe_n;
      if (dq_oe) begin
         checks++;
         if (rd || drove_q) begin
            fails++;
            $display("FAIL R5 contention: dq_oe=%0b read_now=%0b read_prev=%0b expected no drive", dq_oe, rd, drove_q);
         end
      end
      if (wr) begin
         if (!was_wr && CE_MODE) lead_ok = we_low_q;
         wr_len++;
         a_q = addr;
         d_q = dq_out;
         if (oe_n == OE_LOW) oe_bad = 1'b1;
      end
      if (was_wr && !wr) begin
         checks++;
         if (wr_len < WP_MIN) begin
            fails++;
            $display("FAIL R4 write pulse %0d cycles expected >= %0d", wr_len, WP_MIN);
         end
         checks++;
         if (!dq_oe || dq_out != d_q) begin
            fails++;
            $display("FAIL R6 hold: oe=%0b data=%h expected oe=1 data=%h", dq_oe, dq_out, d_q);
         end
         checks++;
         if (oe_bad) begin
            fails++;
            $display("FAIL R10 output enable during write was %0b expected %0b", !OE_LOW, OE_LOW);
         end
         if (CE_MODE) begin
            checks++;
            if (!lead_ok || we_n) begin
               fails++;
               $display("FAIL R7 write strobe lead=%0b at_end_we_n=%0b expected 1 and 0", lead_ok, we_n);
            end
         end
         mem[int'(a_q)] = d_q;
         wr_len = 0;
         oe_bad = 1'b0;
      end
      rd_len   = rd ? rd_len + 1 : 0;
      dq_in    = (rd && rd_len >= RD_MIN && mem.exists(int'(addr))) ? mem[int'(addr)] : 8'hEE;
      drove_q  = rd;
      was_wr   = wr;
      we_low_q = !we_n;
   end

endmodule

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;
   import sram_seq_pkg::*;

   localparam int CLK_PS  = 5000;
   localparam int TURN    = cyc_of(5000, CLK_PS);
   localparam int RD      = cyc_of(10000, CLK_PS);
   localparam int WPS     = cyc_of(8000, CLK_PS);
   localparam int WPL     = cyc_of(12000, CLK_PS);
   localparam int DH      = cyc_of(0, CLK_PS);
   localparam int N_ADDR  = 48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, req_we = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;

   logic        ack [3];
   logic [7:0]  rdata [3];
   logic [16:0] maddr [3];
   logic [7:0]  mdo [3], mdi [3];
   logic        moe [3], ce_n [3], we_n [3], oe_n [3];
   int          mchk [3], mfail [3];

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #2500 clk = ~clk;

   sram_seq_ctrl u_sram_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr),
      .req_wdata_i(req_wdata), .ack_o(ack[0]), .rdata_o(rdata[0]), .mem_addr_o(maddr[0]),
      .mem_dq_o(mdo[0]), .mem_dq_i(mdi[0]), .mem_dq_oe_o(moe[0]), .mem_ce_n_o(ce_n[0]),
      .mem_we_n_o(we_n[0]), .mem_oe_n_o(oe_n[0]));

   sram_seq_ctrl #(.CE_CTRL_WR(1'b1)) u_ce_ctl (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr),
      .req_wdata_i(req_wdata), .ack_o(ack[1]), .rdata_o(rdata[1]), .mem_addr_o(maddr[1]),
      .mem_dq_o(mdo[1]), .mem_dq_i(mdi[1]), .mem_dq_oe_o(moe[1]), .mem_ce_n_o(ce_n[1]),
      .mem_we_n_o(we_n[1]), .mem_oe_n_o(oe_n[1]));

   sram_seq_ctrl #(.OE_LOW_WR(1'b1), .T_WP_LONG_PS(12000)) u_oe_low (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr),
      .req_wdata_i(req_wdata), .ack_o(ack[2]), .rdata_o(rdata[2]), .mem_addr_o(maddr[2]),
      .mem_dq_o(mdo[2]), .mem_dq_i(mdi[2]), .mem_dq_oe_o(moe[2]), .mem_ce_n_o(ce_n[2]),
      .mem_we_n_o(we_n[2]), .mem_oe_n_o(oe_n[2]));

   async_ram_model #(.WP_MIN(WPS), .RD_MIN(RD)) m0 (
      .clk(clk), .addr(maddr[0]), .dq_out(mdo[0]), .dq_oe(moe[0]), .ce_n(ce_n[0]), .we_n(we_n[0]),
      .oe_n(oe_n[0]), .dq_in(mdi[0]), .checks(mchk[0]), .fails(mfail[0]));
   async_ram_model #(.WP_MIN(WPS), .RD_MIN(RD), .CE_MODE(1'b1)) m1 (
      .clk(clk), .addr(maddr[1]), .dq_out(mdo[1]), .dq_oe(moe[1]), .ce_n(ce_n[1]), .we_n(we_n[1]),
      .oe_n(oe_n[1]), .dq_in(mdi[1]), .checks(mchk[1]), .fails(mfail[1]));
   async_ram_model #(.WP_MIN(WPL), .RD_MIN(RD), .OE_LOW(1'b1)) m2 (
      .clk(clk), .addr(maddr[2]), .dq_out(mdo[2]), .dq_oe(moe[2]), .ce_n(ce_n[2]), .we_n(we_n[2]),
      .oe_n(oe_n[2]), .dq_in(mdi[2]), .checks(mchk[2]), .fails(mfail[2]));

   function automatic logic [7:0] pat(input logic [16:0] a);
      return a[7:0] ^ a[15:8] ^ {7'h0, a[16]} ^ 8'h5A;
   endfunction

   function automatic int wr_lat(input int k);
      return TURN + ((k == 2) ? WPL : WPS) + DH + 1;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_op(input logic we, input logic [16:0] a, input logic [7:0] d);
      int n = 0;
      int lat [3];
      bit got [3];
      for (int k = 0; k < 3; k++) begin lat[k] = 0; got[k] = 1'b0; end
      @(negedge clk);
      req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      while (!(got[0] && got[1] && got[2]) && n < 40) begin
         @(negedge clk);
         n++;
         if (n == 1) req = 1'b0;
         for (int k = 0; k < 3; k++) begin
            if (ack[k] && !got[k]) begin
               got[k] = 1'b1;
               lat[k] = n;
               if (!we) check(rdata[k] == d, "R3 R11 read data", rdata[k], d);
            end
         end
      end
      for (int k = 0; k < 3; k++) begin
         if (we) check(lat[k] == wr_lat(k), "R8 R9 write ack latency", lat[k], wr_lat(k));
         else    check(lat[k] == RD + 1,    "R3 R9 read ack latency",  lat[k], RD + 1);
      end
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         check(!ack[k], "R8 ack single cycle", ack[k], 0);
         check(ce_n[k] && !moe[k], "R1 standby after access", {ce_n[k], moe[k]}, 2'b10);
      end
   endtask

   initial begin
      logic [16:0] a;
      repeat (3) @(negedge clk);
      for (int k = 0; k < 3; k++)
         check(ce_n[k] && we_n[k] && oe_n[k] && !moe[k] && !ack[k], "R1 reset strobes",
               {ce_n[k], we_n[k], oe_n[k], moe[k], ack[k]}, 5'b11100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 3; k++)
         check(ce_n[k] && we_n[k] && oe_n[k] && !moe[k], "R1 idle strobes",
               {ce_n[k], we_n[k], oe_n[k], moe[k]}, 4'b1110);
      // R11 address extremes and a spread of addresses
      do_op(1'b1, 17'h00000, pat(17'h00000));
      do_op(1'b1, 17'h1FFFF, pat(17'h1FFFF));
      for (int i = 0; i < N_ADDR; i++) begin
         a = 17'((i * 2731 + 13 * i * i) & 17'h1FFFF);
         do_op(1'b1, a, pat(a));
      end
      do_op(1'b0, 17'h00000, pat(17'h00000));
      do_op(1'b0, 17'h1FFFF, pat(17'h1FFFF));
      for (int i = 0; i < N_ADDR; i++) begin
         a = 17'((i * 2731 + 13 * i * i) & 17'h1FFFF);
         do_op(1'b0, a, pat(a));
      end
      // R5 R2 back-to-back turnaround at one address
      for (int i = 0; i < 8; i++) begin
         a = 17'(17'h10000 >> i);
         do_op(1'b1, a, ~pat(a));
         do_op(1'b0, a, ~pat(a));
         do_op(1'b1, a, pat(a));
         do_op(1'b0, a, pat(a));
      end
      finished = 1'b1;
   end

   initial begin
      int tc, te;
      fork
         wait (finished);
         begin
            repeat (200000) @(posedge clk);
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      tc = checks;
      te = errors;
      for (int k = 0; k < 3; k++) begin
         tc += mchk[k];
         te += mfail[k];
      end
      $display("CHECKS %0d ERRORS %0d", tc, te);
      $finish;
   end

endmodule